// File: doc/BRIEF.md
# Four-Mode Bidirectional Shift Register

This block is a small register whose contents change on each rising clock edge according to a 2-bit mode input. The register can keep its value, move every bit one place toward the top index, move every bit one place toward the bottom index, or take a new word from a parallel input. Each stored bit is fed by its own four-way selector. The mode input drives all of the selectors. The four candidates for a bit are its own value, the value of the bit below, the value of the bit above, and the matching parallel input bit.

A shift leaves one end bit with no neighbour to copy from. A dedicated serial input fills that end bit. One serial input feeds the bottom bit during an upward shift. The other feeds the top bit during a downward shift. Each serial input is used only in its own shift mode. A synchronous reset clears the register. The width is a parameter with a default of four bits.

Top module: `bidir_shift_reg`

## Requirements
- R1: When `rst` is high at a rising edge, every bit of `q_out` becomes 0 after that edge, whatever the mode and data inputs are.
- R2: With `mode` = 2'b00 (hold), `q_out` after the edge equals `q_out` before it.
- R3: With `mode` = 2'b01 (shift up), bit i of `q_out` for i from 1 to WIDTH-1 takes the value that bit i-1 had before the edge.
- R4: With `mode` = 2'b01, bit 0 of `q_out` takes the value of `ser_lo`.
- R5: With `mode` = 2'b10 (shift down), bit i of `q_out` for i from 0 to WIDTH-2 takes the value that bit i+1 had before the edge.
- R6: With `mode` = 2'b10, bit WIDTH-1 of `q_out` takes the value of `ser_hi`.
- R7: With `mode` = 2'b11 (load), `q_out` takes the value of `par_in`, with bit i coming from `par_in[i]`.
- R8: `ser_hi` has no effect in modes 00, 01 and 11. `ser_lo` has no effect in modes 00, 10 and 11. `par_in` has no effect in modes 00, 01 and 10.
- R9: `q_out` is driven directly by the register. A change on any input between two rising edges does not change `q_out` before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates occur on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the register |
| mode | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_lo | input | 1 | Serial bit that enters bit 0 during a shift up |
| ser_hi | input | 1 | Serial bit that enters bit WIDTH-1 during a shift down |
| par_in | input | WIDTH | Parallel word taken in load mode |
| q_out | output | WIDTH | Current register contents |

## Verification
The assertions check five things on every clock: that reset gives zero, that hold leaves the contents stable, the moved body bits and the serial entry bit of each shift direction, and that load copies the parallel word. Together these also rule out any stray influence from the unused inputs in each mode. Other behaviour needs the bench's scenarios to show it. These scenarios are: deliberate toggling of the idle serial and parallel inputs with the result observed at the output, a reset that arrives in the middle of a shift sequence, input changes between edges that must leave the output alone, and long mixed-mode runs compared against an arithmetic model.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;

    // Operation selected by the 2-bit mode input; the codes are fixed.
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;

    localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/bsr_sel4.sv
`timescale 1ns/1ps
// One bit's four-way next-value selector, indexed by the mode code.
module bsr_sel4
    import bsr_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              keep_v,
    input  logic              below_v,
    input  logic              above_v,
    input  logic              load_v,
    output logic              pick
);

    mode_e sel;

    always_comb begin
        sel = mode_e'(mode);
        unique case (sel)
            MODE_HOLD: pick = keep_v;
            MODE_UP:   pick = below_v;
            MODE_DOWN: pick = above_v;
            MODE_LOAD: pick = load_v;
            default:   pick = keep_v;
        endcase
    end

endmodule

// File: rtl/bsr_next.sv
`timescale 1ns/1ps
// Wires one selector per bit to its neighbours; the end bits take the serial inputs.
module bsr_next
    import bsr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [WIDTH-1:0]  cur,
    input  logic              ser_lo,
    input  logic              ser_hi,
    input  logic [WIDTH-1:0]  par_in,
    output logic [WIDTH-1:0]  nxt
);

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] below_w;
    logic [WIDTH-1:0] above_w;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lo_end
            assign below_w[i] = ser_lo;
        end else begin : g_lo_mid
            assign below_w[i] = cur[i-1];
        end

        if (i == TOP) begin : g_hi_end
            assign above_w[i] = ser_hi;
        end else begin : g_hi_mid
            assign above_w[i] = cur[i+1];
        end

        bsr_sel4 u_sel (
            .mode    (mode),
            .keep_v  (cur[i]),
            .below_v (below_w[i]),
            .above_v (above_w[i]),
            .load_v  (par_in[i]),
            .pick    (nxt[i])
        );
    end

endmodule

// File: rtl/bidir_shift_reg.sv
`timescale 1ns/1ps
// Four-mode bidirectional shift register, two-process form.
module bidir_shift_reg
    import bsr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              ser_lo,
    input  logic              ser_hi,
    input  logic [WIDTH-1:0]  par_in,
    output logic [WIDTH-1:0]  q_out
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } state_t;

    state_t regs_d;
    state_t regs_q;

    logic [WIDTH-1:0] sel_w;

    bsr_next #(.WIDTH(WIDTH)) u_next (
        .mode   (mode),
        .cur    (regs_q.bits),
        .ser_lo (ser_lo),
        .ser_hi (ser_hi),
        .par_in (par_in),
        .nxt    (sel_w)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.bits = '0;
        end else begin
            regs_d.bits = sel_w;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign q_out = regs_q.bits;

endmodule

// File: rtl/bsr_checker.sv
`timescale 1ns/1ps
// Port-level properties, bound onto the top module.
module bsr_checker #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic             ser_lo,
    input logic             ser_hi,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q_out
);

    localparam int unsigned TOP = WIDTH - 1;

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (q_out == '0)); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> $stable(q_out)); // R2

    AST_UP_BODY: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> (q_out[TOP:1] == $past(q_out[TOP-1:0]))); // R3

    AST_UP_SERIAL: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> (q_out[0] == $past(ser_lo))); // R4

    AST_DOWN_BODY: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> (q_out[TOP-1:0] == $past(q_out[TOP:1]))); // R5

    AST_DOWN_SERIAL: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> (q_out[TOP] == $past(ser_hi))); // R6

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> (q_out == $past(par_in))); // R7

endmodule

bind bidir_shift_reg bsr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .ser_lo (ser_lo),
    .ser_hi (ser_hi),
    .par_in (par_in),
    .q_out  (q_out)
);

// File: tb/bidir_shift_reg_tb_top.sv
`timescale 1ns/1ps
module bidir_shift_reg_tb_top;

    localparam int W = 4;
    localparam int MODV = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic         ser_lo = 1'b0;
    logic         ser_hi = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q_out;

    int checks = 0;
    int failures = 0;
    int exp_val = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bidir_shift_reg #(.WIDTH(W)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .ser_lo (ser_lo),
        .ser_hi (ser_hi),
        .par_in (par_in),
        .q_out  (q_out)
    );

    task automatic check(input int got, input int want, input string req);
        checks++;
        if (got != want) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, want);
        end
    endtask

    // Drive one cycle's inputs (caller is away from the edge), advance the
    // arithmetic model at the edge, then compare at the following falling edge.
    task automatic step(input logic [1:0] m, input logic sl, input logic sh,
                        input logic [W-1:0] p, input logic r, input string req);
        mode = m; ser_lo = sl; ser_hi = sh; par_in = p; rst = r;
        @(posedge clk);
        if (r) exp_val = 0;
        else begin
            case (m)
                2'b00: exp_val = exp_val;
                2'b01: exp_val = (exp_val * 2 + int'(sl)) % MODV;
                2'b10: exp_val = exp_val / 2 + int'(sh) * (MODV / 2);
                default: exp_val = int'(p);
            endcase
        end
        @(negedge clk);
        check(int'(q_out), exp_val, req);
    endtask

    initial begin
        @(negedge clk);
        step(2'b11, 1'b1, 1'b1, 4'hF, 1'b1, "R1 reset with load pending");
        step(2'b11, 1'b0, 1'b0, 4'hA, 1'b0, "R7 load 1010");
        step(2'b00, 1'b1, 1'b1, 4'h5, 1'b0, "R2 hold");
        step(2'b00, 1'b0, 1'b1, 4'hF, 1'b0, "R8 idle inputs in hold");
        step(2'b01, 1'b1, 1'b0, 4'h0, 1'b0, "R3 R4 shift up ser_lo=1");
        step(2'b01, 1'b0, 1'b1, 4'hF, 1'b0, "R8 ser_hi and par_in ignored in up");
        step(2'b01, 1'b1, 1'b1, 4'h0, 1'b0, "R4 shift up ser_lo=1");
        step(2'b10, 1'b1, 1'b0, 4'hF, 1'b0, "R8 ser_lo and par_in ignored in down");
        step(2'b10, 1'b0, 1'b1, 4'h0, 1'b0, "R5 R6 shift down ser_hi=1");
        step(2'b10, 1'b1, 1'b1, 4'h3, 1'b0, "R6 shift down ser_hi=1");
        step(2'b11, 1'b1, 1'b1, 4'h6, 1'b0, "R8 serials ignored in load");
        step(2'b11, 1'b0, 1'b0, 4'h1, 1'b0, "R7 load 0001");
        for (int k = 0; k < W; k++)
            step(2'b01, 1'b0, 1'b1, 4'h0, 1'b0, "R3 walk bit to top and out");
        step(2'b11, 1'b0, 1'b0, 4'h8, 1'b0, "R7 load 1000");
        for (int k = 0; k < W; k++)
            step(2'b10, 1'b0, 1'b0, 4'hF, 1'b0, "R5 walk bit to bottom and out");
        step(2'b11, 1'b0, 1'b0, 4'hB, 1'b0, "R7 load 1011");
        step(2'b01, 1'b1, 1'b0, 4'h0, 1'b0, "R3 shift up before reset");
        step(2'b01, 1'b1, 1'b0, 4'h0, 1'b1, "R1 reset during shift");
        step(2'b00, 1'b1, 1'b1, 4'hF, 1'b0, "R1 held zero after reset");

        // Inputs change between edges: output must not move before the edge.
        step(2'b11, 1'b0, 1'b0, 4'h9, 1'b0, "R7 load 1001");
        mode = 2'b11; par_in = 4'h6; ser_lo = 1'b1; ser_hi = 1'b1; rst = 1'b1;
        #2;
        check(int'(q_out), 9, "R9 no change between edges");
        rst = 1'b0;
        #1;
        check(int'(q_out), 9, "R9 no change after second input change");

        for (int k = 0; k < 300; k++) begin
            logic [1:0]   m;
            logic [W-1:0] p;
            logic         r;
            m = 2'($urandom_range(0, 3));
            p = W'($urandom_range(0, MODV - 1));
            r = ($urandom_range(0, 15) == 0);
            case (m)
                2'b00: step(m, 1'($urandom), 1'($urandom), p, r, "R2 random hold");
                2'b01: step(m, 1'($urandom), 1'($urandom), p, r, "R3 R4 random up");
                2'b10: step(m, 1'($urandom), 1'($urandom), p, r, "R5 R6 random down");
                default: step(m, 1'($urandom), 1'($urandom), p, r, "R7 random load");
            endcase
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule